// File: doc/BRIEF.md
# SRAM zero-fill initialization engine

This block clears a word-organised RAM on software request. A write of 1 to the clear-enable bit of the memory-control register starts the clear. The engine then walks every word address from 0 up to the last word, one word per clock. Each write stores zero data, asserts every byte enable, and carries the parity bits that are correct for a zero byte.

While the clear runs, a read-only busy flag is 1. During that time the block takes the RAM write port for itself and refuses normal traffic: any request gets a stall indication and is dropped, not queued. When the engine is idle, normal read and write requests pass straight to the RAM port, and parity is generated for the write data. The clear-enable bit clears itself when the last word has been written.

Top module: `sram_zfill_top`

## Requirements
- R1: The memory-control register sits at byte offset 0xC. Its read data has bit 0 = clear enable, bit 1 = busy, and bits 31:2 = 0. A read at any other offset returns 0.
- R2: After reset, both control bits read 0 and the RAM port is idle (ram_we = 0, ram_re = 0).
- R3: A register write at offset 0xC with wdata bit 0 = 1 while idle makes both control bits read 1 from the next clock.
- R4: While busy, ram_we is 1 in every cycle. ram_addr starts at 0 and rises by one per cycle to 2**ADDR_W-1, ram_wdata is 0 and every ram_be bit is 1. Afterwards every word of the RAM holds zero.
- R5: Each byte has one parity bit (ram_wpar bit i covers data bits 8i+7:8i), and with ODD_PARITY=1 each group of 9 bits holds an odd number of ones. Clear writes therefore carry ram_wpar = all ones.
- R6: The busy period lasts exactly 2**ADDR_W cycles. In the cycle after the last word is written, both control bits read 0.
- R7: While busy, a request with req_valid = 1 sees req_stall = 1. Its read never reaches the RAM (ram_re = 0), its data never replaces the clear data, and it is not replayed after the clear.
- R8: Register writes at 0xC while busy have no effect. Writing 0 does not abort the clear, and writing 1 does not restart it. The address sequence continues unbroken.
- R9: When idle, req_stall is 0. A request drives ram_we = req_valid & req_we, ram_re = req_valid & ~req_we, and its address, data and byte enables, with parity computed from req_wdata.
- R10: A write at 0xC with bit 0 = 0, or a write at any other offset, does not start a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| req_valid | input | 1 | Normal request valid |
| req_we | input | 1 | Normal request is a write |
| req_addr | input | ADDR_W | Normal request word address |
| req_wdata | input | DATA_W | Normal request write data |
| req_be | input | DATA_W/8 | Normal request byte enables |
| req_stall | output | 1 | Request refused because a clear is running |
| ram_we | output | 1 | RAM write strobe |
| ram_re | output | 1 | RAM read strobe |
| ram_addr | output | ADDR_W | RAM word address |
| ram_wdata | output | DATA_W | RAM write data |
| ram_be | output | DATA_W/8 | RAM byte enables |
| ram_wpar | output | DATA_W/8 | RAM per-byte parity bits |

## Verification
Two kinds of event can fall in the same cycle: a software trigger and a normal request, and a control-register write and a clear step. The bench places a normal write in the very cycle of the trigger write, and expects that write to reach the RAM unchanged because busy only rises at the next edge. During the clear it issues random requests together with abort and restart writes to the control register. Each of those cycles is judged on its own: the clear address must keep counting, the data must stay zero, and req_stall must follow req_valid. A shadow RAM built from the observed write port is then compared word by word with zero data and all-ones parity.

// File: rtl/sram_zfill_pkg.sv
package sram_zfill_pkg;
   localparam int unsigned REG_DW  = 32;
   localparam int unsigned BIT_EN  = 0;
   localparam int unsigned BIT_BSY = 1;

   typedef enum logic {
      SEQ_IDLE  = 1'b0,
      SEQ_CLEAR = 1'b1
   } seq_state_e;
endpackage

// File: rtl/sram_zfill_seq.sv
module sram_zfill_seq #(
   parameter int unsigned ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              busy,
   output logic              done,
   output logic [ADDR_W-1:0] clr_addr
);
   import sram_zfill_pkg::*;

   localparam logic [ADDR_W-1:0] LAST_WORD = {ADDR_W{1'b1}};

   seq_state_e        state_q;
   logic [ADDR_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         cnt_q   <= '0;
      end else begin
         unique case (state_q)
            SEQ_IDLE: begin
               if (start) begin
                  state_q <= SEQ_CLEAR;
                  cnt_q   <= '0;
               end
            end
            SEQ_CLEAR: begin
               if (cnt_q == LAST_WORD) begin
                  state_q <= SEQ_IDLE;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign busy     = (state_q == SEQ_CLEAR);
   assign done     = busy && (cnt_q == LAST_WORD);
   assign clr_addr = cnt_q;
endmodule

// File: rtl/sram_zfill_regs.sv
module sram_zfill_regs #(
   parameter int unsigned     REG_AW      = 4,
   parameter logic [REG_AW-1:0] CTRL_OFFSET = 4'hC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   input  logic              busy,
   input  logic              done,
   output logic              start,
   output logic [31:0]       reg_rdata
);
   import sram_zfill_pkg::*;

   logic en_q;
   logic hit;

   assign hit   = (reg_addr == CTRL_OFFSET);
   assign start = reg_wr && hit && reg_wdata[BIT_EN] && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= 1'b0;
      end else if (start) begin
         en_q <= 1'b1;
      end else if (done) begin
         en_q <= 1'b0;
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (hit) begin
         reg_rdata[BIT_EN]  = en_q;
         reg_rdata[BIT_BSY] = busy;
      end
   end
endmodule

// File: rtl/sram_zfill_port.sv
module sram_zfill_port #(
   parameter int unsigned ADDR_W     = 6,
   parameter int unsigned DATA_W     = 32,
   parameter bit          ODD_PARITY = 1'b1
) (
   input  logic                   busy,
   input  logic [ADDR_W-1:0]      clr_addr,
   input  logic                   req_valid,
   input  logic                   req_we,
   input  logic [ADDR_W-1:0]      req_addr,
   input  logic [DATA_W-1:0]      req_wdata,
   input  logic [DATA_W/8-1:0]    req_be,
   output logic                   req_stall,
   output logic                   ram_we,
   output logic                   ram_re,
   output logic [ADDR_W-1:0]      ram_addr,
   output logic [DATA_W-1:0]      ram_wdata,
   output logic [DATA_W/8-1:0]    ram_be,
   output logic [DATA_W/8-1:0]    ram_wpar
);
   localparam int unsigned BE_W = DATA_W / 8;

   logic [BE_W-1:0] req_par;
   logic [BE_W-1:0] zero_par;

   for (genvar g = 0; g < BE_W; g++) begin : g_lane
      if (ODD_PARITY) begin : g_odd
         assign req_par[g]  = ~(^req_wdata[g*8 +: 8]);
         assign zero_par[g] = 1'b1;
      end else begin : g_even
         assign req_par[g]  = ^req_wdata[g*8 +: 8];
         assign zero_par[g] = 1'b0;
      end
   end

   always_comb begin
      req_stall = busy && req_valid;
      if (busy) begin
         ram_we    = 1'b1;
         ram_re    = 1'b0;
         ram_addr  = clr_addr;
         ram_wdata = '0;
         ram_be    = '1;
         ram_wpar  = zero_par;
      end else begin
         ram_we    = req_valid && req_we;
         ram_re    = req_valid && !req_we;
         ram_addr  = req_addr;
         ram_wdata = req_wdata;
         ram_be    = req_be;
         ram_wpar  = req_par;
      end
   end
endmodule

// File: rtl/sram_zfill_top.sv
module sram_zfill_top #(
   parameter int unsigned       ADDR_W      = 6,
   parameter int unsigned       DATA_W      = 32,
   parameter int unsigned       REG_AW      = 4,
   parameter logic [REG_AW-1:0] CTRL_OFFSET = 4'hC,
   parameter bit                ODD_PARITY  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic [REG_AW-1:0]   reg_addr,
   input  logic [31:0]         reg_wdata,
   output logic [31:0]         reg_rdata,
   input  logic                req_valid,
   input  logic                req_we,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [DATA_W-1:0]   req_wdata,
   input  logic [DATA_W/8-1:0] req_be,
   output logic                req_stall,
   output logic                ram_we,
   output logic                ram_re,
   output logic [ADDR_W-1:0]   ram_addr,
   output logic [DATA_W-1:0]   ram_wdata,
   output logic [DATA_W/8-1:0] ram_be,
   output logic [DATA_W/8-1:0] ram_wpar
);
   if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_dw
      $error("sram_zfill_top: DATA_W must be a non-zero multiple of 8");
   end
   if (ADDR_W < 1 || ADDR_W > 24) begin : g_bad_aw
      $error("sram_zfill_top: ADDR_W must lie in 1..24");
   end
   if (REG_AW < 2) begin : g_bad_raw
      $error("sram_zfill_top: REG_AW too small");
   end

   logic              busy;
   logic              done;
   logic              start;
   logic [ADDR_W-1:0] clr_addr;

   sram_zfill_regs #(
      .REG_AW      (REG_AW),
      .CTRL_OFFSET (CTRL_OFFSET)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .busy      (busy),
      .done      (done),
      .start     (start),
      .reg_rdata (reg_rdata)
   );

   sram_zfill_seq #(
      .ADDR_W (ADDR_W)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .busy     (busy),
      .done     (done),
      .clr_addr (clr_addr)
   );

   sram_zfill_port #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .ODD_PARITY (ODD_PARITY)
   ) u_port (
      .busy      (busy),
      .clr_addr  (clr_addr),
      .req_valid (req_valid),
      .req_we    (req_we),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .req_be    (req_be),
      .req_stall (req_stall),
      .ram_we    (ram_we),
      .ram_re    (ram_re),
      .ram_addr  (ram_addr),
      .ram_wdata (ram_wdata),
      .ram_be    (ram_be),
      .ram_wpar  (ram_wpar)
   );
endmodule

// File: rtl/sram_zfill_chk.sv
module sram_zfill_chk #(
   parameter int unsigned       ADDR_W      = 6,
   parameter int unsigned       DATA_W      = 32,
   parameter int unsigned       REG_AW      = 4,
   parameter logic [REG_AW-1:0] CTRL_OFFSET = 4'hC
) (
   input logic                clk,
   input logic                rst_n,
   input logic                busy,
   input logic                reg_wr,
   input logic [REG_AW-1:0]   reg_addr,
   input logic [31:0]         reg_wdata,
   input logic                req_valid,
   input logic                req_stall,
   input logic                ram_we,
   input logic                ram_re,
   input logic [ADDR_W-1:0]   ram_addr,
   input logic [DATA_W-1:0]   ram_wdata,
   input logic [DATA_W/8-1:0] ram_be
);
   localparam logic [ADDR_W-1:0] LAST_WORD = {ADDR_W{1'b1}};

   // R7
   busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && req_valid) |-> req_stall);

   // R7
   busy_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !ram_re);

   // R4
   clear_zero_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (ram_we && ram_wdata == '0 && (&ram_be)));

   // R4
   clear_addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ram_addr != LAST_WORD) |=> (busy && ram_addr == $past(ram_addr) + 1'b1));

   // R6
   clear_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ram_addr == LAST_WORD) |=> !busy);

   // R3
   start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && reg_wr && reg_addr == CTRL_OFFSET && reg_wdata[0])
         |=> (busy && ram_addr == '0));

   // R10
   no_false_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !(reg_wr && reg_addr == CTRL_OFFSET && reg_wdata[0])) |=> !busy);
endmodule

bind sram_zfill_top sram_zfill_chk #(
   .ADDR_W      (ADDR_W),
   .DATA_W      (DATA_W),
   .REG_AW      (REG_AW),
   .CTRL_OFFSET (CTRL_OFFSET)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .reg_wr    (reg_wr),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .req_valid (req_valid),
   .req_stall (req_stall),
   .ram_we    (ram_we),
   .ram_re    (ram_re),
   .ram_addr  (ram_addr),
   .ram_wdata (ram_wdata),
   .ram_be    (ram_be)
);

// File: tb/sram_zfill_top_tb_top.sv
module sram_zfill_top_tb_top;
   localparam int unsigned ADDR_W = 5;
   localparam int unsigned DATA_W = 32;
   localparam int unsigned BE_W   = DATA_W / 8;
   localparam int unsigned DEPTH  = 1 << ADDR_W;
   localparam int unsigned REG_AW = 4;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                reg_wr = 1'b0;
   logic [REG_AW-1:0]   reg_addr = '0;
   logic [31:0]         reg_wdata = '0;
   logic [31:0]         reg_rdata;
   logic                req_valid = 1'b0;
   logic                req_we = 1'b0;
   logic [ADDR_W-1:0]   req_addr = '0;
   logic [DATA_W-1:0]   req_wdata = '0;
   logic [BE_W-1:0]     req_be = '0;
   logic                req_stall;
   logic                ram_we;
   logic                ram_re;
   logic [ADDR_W-1:0]   ram_addr;
   logic [DATA_W-1:0]   ram_wdata;
   logic [BE_W-1:0]     ram_be;
   logic [BE_W-1:0]     ram_wpar;

   int unsigned checks = 0;
   int unsigned errors = 0;
   bit          finished = 1'b0;

   logic [DATA_W-1:0] shadow_mem [DEPTH];
   logic [BE_W-1:0]   shadow_par [DEPTH];

   always #2 clk = ~clk;

   sram_zfill_top #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .REG_AW (REG_AW)
   ) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .req_valid (req_valid),
      .req_we    (req_we),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .req_be    (req_be),
      .req_stall (req_stall),
      .ram_we    (ram_we),
      .ram_re    (ram_re),
      .ram_addr  (ram_addr),
      .ram_wdata (ram_wdata),
      .ram_be    (ram_be),
      .ram_wpar  (ram_wpar)
   );

   // Shadow RAM built only from the observed write port.
   always @(posedge clk) begin
      if (rst_n && ram_we) begin
         for (int b = 0; b < BE_W; b++) begin
            if (ram_be[b]) begin
               shadow_mem[ram_addr][b*8 +: 8] <= ram_wdata[b*8 +: 8];
               shadow_par[ram_addr][b]        <= ram_wpar[b];
            end
         end
      end
   end

   function automatic logic [BE_W-1:0] odd_par(input logic [DATA_W-1:0] d);
      logic [BE_W-1:0] p;
      for (int b = 0; b < BE_W; b++) begin
         p[b] = ~(^d[b*8 +: 8]);
      end
      return p;
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle_inputs();
      reg_wr    = 1'b0;
      reg_wdata = '0;
      req_valid = 1'b0;
      req_we    = 1'b0;
   endtask

   task automatic rand_req();
      req_valid = $urandom_range(0, 1) == 1;
      req_we    = $urandom_range(0, 1) == 1;
      req_addr  = ADDR_W'($urandom);
      req_wdata = DATA_W'($urandom);
      req_be    = BE_W'($urandom);
   endtask

   task automatic check_pass(input string tag);
      check({tag, " stall"}, 64'(req_stall), 64'd0);
      check({tag, " we"}, 64'(ram_we), 64'(req_valid && req_we));
      check({tag, " re"}, 64'(ram_re), 64'(req_valid && !req_we));
      if (req_valid) begin
         check({tag, " addr"}, 64'(ram_addr), 64'(req_addr));
         check({tag, " data"}, 64'(ram_wdata), 64'(req_wdata));
         check({tag, " be"}, 64'(ram_be), 64'(req_be));
         check({tag, " par"}, 64'(ram_wpar), 64'(odd_par(req_wdata)));
      end
   endtask

   task automatic run_clear(input bool_disturb);
      // Trigger cycle: a normal write lands in the same cycle (R9).
      @(negedge clk);
      reg_wr    = 1'b1;
      reg_addr  = 4'hC;
      reg_wdata = 32'h1;
      req_valid = 1'b1;
      req_we    = 1'b1;
      req_addr  = ADDR_W'(7);
      req_wdata = 32'hA5C3_0F11;
      req_be    = '1;
      #1;
      check_pass("R9 trigger-cycle");
      check("R3 not busy before edge", 64'(reg_rdata), 64'd0);
      for (int k = 0; k < int'(DEPTH); k++) begin
         @(negedge clk);
         idle_inputs();
         reg_addr = 4'hC;
         rand_req();
         if (bool_disturb && k == 3) begin
            reg_wr = 1'b1; reg_wdata = 32'h0;      // R8 abort attempt
         end
         if (bool_disturb && k == 5) begin
            reg_wr = 1'b1; reg_wdata = 32'hFFFF_FFFF; // R8 restart attempt
         end
         #1;
         check("R3 R6 busy+enable", 64'(reg_rdata), 64'd3);
         check("R4 R8 clear addr", 64'(ram_addr), 64'(k));
         check("R4 clear we", 64'(ram_we), 64'd1);
         check("R4 clear data", 64'(ram_wdata), 64'd0);
         check("R4 clear be", 64'(ram_be), 64'({BE_W{1'b1}}));
         check("R5 clear parity", 64'(ram_wpar), 64'({BE_W{1'b1}}));
         check("R7 stall", 64'(req_stall), 64'(req_valid));
         check("R7 no read", 64'(ram_re), 64'd0);
      end
      @(negedge clk);
      idle_inputs();
      reg_addr = 4'hC;
      #1;
      check("R6 done bits", 64'(reg_rdata), 64'd0);
      check("R7 no replay we", 64'(ram_we), 64'd0);
      check("R7 no replay re", 64'(ram_re), 64'd0);
   endtask

   initial begin
      void'($urandom(32'd1234));
      idle_inputs();
      repeat (3) @(negedge clk);
      #1;
      reg_addr = 4'hC;
      #1;
      check("R2 reset ctrl", 64'(reg_rdata), 64'd0);
      check("R2 reset we", 64'(ram_we), 64'd0);
      check("R2 reset re", 64'(ram_re), 64'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // Random normal traffic while idle (R9).
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         idle_inputs();
         rand_req();
         req_valid = 1'b1;
         if (i < int'(DEPTH)) begin
            req_we = 1'b1; req_addr = ADDR_W'(i); req_be = '1;
            req_wdata = DATA_W'($urandom) | 32'h0101_0101;
         end
         reg_addr = 4'(4 * $urandom_range(0, 2));
         #1;
         check_pass("R9 idle");
         check("R1 other offset", 64'(reg_rdata), 64'd0);
      end

      // Writes that must not start a clear (R10).
      @(negedge clk);
      idle_inputs();
      reg_wr = 1'b1; reg_addr = 4'hC; reg_wdata = 32'hFFFF_FFFE;
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 4'h8; reg_wdata = 32'hFFFF_FFFF;
      @(negedge clk);
      idle_inputs();
      reg_addr = 4'hC;
      #1;
      check("R10 no start", 64'(reg_rdata), 64'd0);
      check("R10 no clear write", 64'(ram_we), 64'd0);

      run_clear(1'b1);
      for (int w = 0; w < int'(DEPTH); w++) begin
         check("R4 word zero", 64'(shadow_mem[w]), 64'd0);
         check("R5 word parity", 64'(shadow_par[w]), 64'({BE_W{1'b1}}));
      end

      // Normal traffic works again after the clear (R9).
      @(negedge clk);
      idle_inputs();
      req_valid = 1'b1; req_we = 1'b0; req_addr = ADDR_W'(3);
      #1;
      check_pass("R9 after clear");

      run_clear(1'b0);

      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #(4 * 200000);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule